// File: doc/BRIEF.md
# Bit-Serial ATM Cell Delineator

This block recovers ATM cell boundaries from a raw serial line that carries no framing pulse. Each accepted bit is shifted into a 40-bit window. While hunting, the block checks every bit position: the first 32 bits of the window are treated as a candidate header and their header error check is compared with the last 8 bits. A mismatch costs one bit of slip, because the next accepted bit moves the window on by one position. The first match fixes both the byte phase and the cell phase.

After that, the block checks only one window per cell, 53 bytes apart. A confirmation machine promotes the link to the synchronised state, or drops it back to hunting. Once byte alignment is known, the block emits the stream as bytes and marks the first header byte of every cell. It also reports the delineation state and a loss-of-delineation flag. Descrambling of the payload and any downstream buffering are left to other blocks.

Top module: `cell_delineator`

## Requirements
- R1: While `rst` is high, and on the first edge after it, `state_o` is 0 (hunting), `locd_o` is 1, and `byte_vld_o` and `cell_start_o` are 0.
- R2: The check value is a CRC-8 with generator x^8+x^2+x+1 (0x07). It starts from zero and is computed over 32 header bits, first-received bit first, then XORed with 0x55. It is compared with the 8 bits received after those 32. Every byte travels most significant bit first.
- R3: While hunting, every accepted bit moves the window by exactly one position. No comparison is made until 40 bits have been accepted since reset. The first window that matches moves `state_o` to 1 (presync) on the edge that takes its last bit. That holds for any bit offset of the header in the stream.
- R4: While not hunting, the block emits one byte for every 8 accepted bits. A stream byte appears on `byte_o`, with `byte_vld_o` high, on the edge that takes the last bit of the fourth byte after it. `cell_start_o` is high exactly when the emitted byte is the first header byte of a cell, which is once every 53 bytes.
- R5: In presync, the header window is checked once per cell, 53 bytes after the previous one. After 6 consecutive correct checks, `state_o` becomes 2 (sync) and `locd_o` falls on that same edge.
- R6: In presync, one failed check returns `state_o` to 0. No byte is emitted on that edge.
- R7: In sync, a correct check clears the run of failures. The 7th consecutive failed check returns `state_o` to 0 and raises `locd_o`, with no byte emitted on that edge. Fewer than 7 failures leave the block in sync and still emitting.
- R8: A cycle with `bit_vld_o`'s input `bit_vld_i` low is ignored. `bit_i` does not enter the window, the state does not change, and no byte is emitted.
- R9: While `state_o` is 0, `byte_vld_o` and `cell_start_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld_i | input | 1 | Qualifies `bit_i` for this cycle |
| bit_i | input | 1 | Serial line bit |
| byte_o | output | 8 | Byte-aligned stream, delayed by 4 bytes |
| byte_vld_o | output | 1 | `byte_o` carries a new byte |
| cell_start_o | output | 1 | Emitted byte is the first header byte of a cell |
| state_o | output | 2 | 0 hunting, 1 presync, 2 sync |
| locd_o | output | 1 | Loss of cell delineation |

## Verification
All results are registered on the edge that accepts the deciding bit. The state and loss flag therefore change on the edge that takes the last bit of a header check byte. A byte is emitted on the edge that takes the final bit of the fourth byte after it. The bench drives each bit half a period before the edge and samples every output on the following falling edge. It compares the state after the fortieth bit of each header, and the byte stream after every accepted bit against its own byte list. Idle cycles are inserted between bits, and the bench checks on the very next falling edge that these cycles leave the state and the byte output untouched.

// File: rtl/cd_pkg.sv
package cd_pkg;
  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_PRESYNC = 2'd1,
    ST_SYNC    = 2'd2
  } cd_state_e;
endpackage

// File: rtl/cd_hec.sv
module cd_hec #(
  parameter int              HDR_BITS = 32,
  parameter int              HEC_BITS = 8,
  parameter logic [7:0]      POLY     = 8'h07,
  parameter logic [7:0]      COSET    = 8'h55
) (
  input  logic [HDR_BITS-1:0] hdr_i,
  output logic [HEC_BITS-1:0] hec_o
);
  logic [HEC_BITS-1:0] crc_v;
  logic                fb_v;

  // Bit-serial CRC unrolled over the header, first-received bit first.
  always_comb begin
    crc_v = '0;
    fb_v  = 1'b0;
    for (int i = 0; i < HDR_BITS; i++) begin
      fb_v  = crc_v[HEC_BITS-1] ^ hdr_i[HDR_BITS-1-i];
      crc_v = {crc_v[HEC_BITS-2:0], 1'b0} ^ (fb_v ? POLY[HEC_BITS-1:0] : '0);
    end
    hec_o = crc_v ^ COSET[HEC_BITS-1:0];
  end
endmodule

// File: rtl/cd_window.sv
module cd_window #(
  parameter int WIN = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bit_vld_i,
  input  logic           bit_i,
  output logic [WIN-1:0] win_nxt_o,
  output logic           full_nxt_o
);
  localparam int FW = $clog2(WIN + 1);

  logic [WIN-1:0] win_q;
  logic [FW-1:0]  fill_q;

  always_comb win_nxt_o  = bit_vld_i ? {win_q[WIN-2:0], bit_i} : win_q;
  always_comb full_nxt_o = bit_vld_i && (fill_q >= FW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (bit_vld_i) begin
      win_q <= win_nxt_o;
      if (fill_q != FW'(WIN)) fill_q <= fill_q + 1'b1;
    end
  end

  // R8
  win_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld_i) |-> $stable(win_q));
endmodule

// File: rtl/cd_fsm.sv
module cd_fsm
  import cd_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int DELTA      = 6,
  parameter int ALPHA      = 7
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bit_vld_i,
  input  logic      full_i,
  input  logic      hec_ok_i,
  output cd_state_e state_o,
  output logic      locd_o,
  output logic      emit_o,
  output logic      start_o
);
  localparam int BW = $clog2(CELL_BYTES);
  localparam int GW = $clog2(DELTA + 1);
  localparam int AW = $clog2(ALPHA + 1);

  cd_state_e      st_q, st_d;
  logic [2:0]     bit_q, bit_d;
  logic [BW-1:0]  byte_q, byte_d;
  logic [GW-1:0]  good_q, good_d;
  logic [AW-1:0]  bad_q, bad_d;
  logic           locd_q, locd_d;
  logic           at_edge, at_check;

  always_comb begin
    at_edge  = (bit_q == 3'd7);
    at_check = at_edge && (byte_q == BW'(CELL_BYTES - 1));
  end

  always_comb begin
    st_d    = st_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    good_d  = good_q;
    bad_d   = bad_q;
    locd_d  = locd_q;
    emit_o  = 1'b0;
    start_o = 1'b0;
    if (bit_vld_i) begin
      if (st_q == ST_HUNT) begin
        if (full_i && hec_ok_i) begin
          st_d    = ST_PRESYNC;
          bit_d   = '0;
          byte_d  = '0;
          good_d  = '0;
          bad_d   = '0;
          emit_o  = 1'b1;
          start_o = 1'b1;
        end
      end else begin
        bit_d = bit_q + 3'd1;
        if (at_edge) byte_d = at_check ? '0 : byte_q + 1'b1;
        if (at_check) begin
          if (st_q == ST_PRESYNC) begin
            if (hec_ok_i) begin
              emit_o  = 1'b1;
              start_o = 1'b1;
              if (good_q == GW'(DELTA - 1)) begin
                st_d   = ST_SYNC;
                locd_d = 1'b0;
                bad_d  = '0;
              end else begin
                good_d = good_q + 1'b1;
              end
            end else begin
              st_d = ST_HUNT;
            end
          end else begin
            if (hec_ok_i) begin
              bad_d   = '0;
              emit_o  = 1'b1;
              start_o = 1'b1;
            end else if (bad_q == AW'(ALPHA - 1)) begin
              st_d   = ST_HUNT;
              locd_d = 1'b1;
            end else begin
              bad_d   = bad_q + 1'b1;
              emit_o  = 1'b1;
              start_o = 1'b1;
            end
          end
        end else if (at_edge) begin
          emit_o = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_HUNT;
      bit_q  <= '0;
      byte_q <= '0;
      good_q <= '0;
      bad_q  <= '0;
      locd_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      byte_q <= byte_d;
      good_q <= good_d;
      bad_q  <= bad_d;
      locd_q <= locd_d;
    end
  end

  always_comb begin
    state_o = st_q;
    locd_o  = locd_q;
  end

  // R5
  enter_sync_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(st_q == ST_SYNC) |-> ($past(st_q) == ST_PRESYNC) && ($past(good_q) == GW'(DELTA - 1)));
  // R7
  sync_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_HUNT && $past(st_q) == ST_SYNC) |-> locd_q && ($past(bad_q) == AW'(ALPHA - 1)));
  // R5
  locd_state_chk: assert property (@(posedge clk) disable iff (rst)
    locd_q == (st_q != ST_SYNC));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(bit_vld_i) |-> ($stable(st_q) && $stable(bit_q) && $stable(byte_q)));
  // R4
  byte_range_chk: assert property (@(posedge clk) disable iff (rst)
    byte_q < BW'(CELL_BYTES));
endmodule

// File: rtl/cell_delineator.sv
module cell_delineator
  import cd_pkg::*;
#(
  parameter int         HDR_BITS   = 32,
  parameter int         HEC_BITS   = 8,
  parameter logic [7:0] POLY       = 8'h07,
  parameter logic [7:0] COSET      = 8'h55,
  parameter int         CELL_BYTES = 53,
  parameter int         DELTA      = 6,
  parameter int         ALPHA      = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       bit_vld_i,
  input  logic       bit_i,
  output logic [7:0] byte_o,
  output logic       byte_vld_o,
  output logic       cell_start_o,
  output logic [1:0] state_o,
  output logic       locd_o
);
  localparam int WIN = HDR_BITS + HEC_BITS;

  logic [WIN-1:0]      win_nxt;
  logic                full_nxt;
  logic [HEC_BITS-1:0] hec_calc;
  logic                hec_ok;
  logic                emit, start;
  cd_state_e           st;

  cd_window #(.WIN(WIN)) u_win (
    .clk        (clk),
    .rst        (rst),
    .bit_vld_i  (bit_vld_i),
    .bit_i      (bit_i),
    .win_nxt_o  (win_nxt),
    .full_nxt_o (full_nxt)
  );

  cd_hec #(.HDR_BITS(HDR_BITS), .HEC_BITS(HEC_BITS), .POLY(POLY), .COSET(COSET)) u_hec (
    .hdr_i (win_nxt[WIN-1:HEC_BITS]),
    .hec_o (hec_calc)
  );

  always_comb hec_ok = (hec_calc == win_nxt[HEC_BITS-1:0]);

  cd_fsm #(.CELL_BYTES(CELL_BYTES), .DELTA(DELTA), .ALPHA(ALPHA)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bit_vld_i (bit_vld_i),
    .full_i    (full_nxt),
    .hec_ok_i  (hec_ok),
    .state_o   (st),
    .locd_o    (locd_o),
    .emit_o    (emit),
    .start_o   (start)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_o       <= '0;
      byte_vld_o   <= 1'b0;
      cell_start_o <= 1'b0;
    end else begin
      byte_vld_o   <= emit;
      cell_start_o <= start;
      if (emit) byte_o <= win_nxt[WIN-1 -: 8];
    end
  end

  always_comb state_o = st;

  // R9
  no_out_hunt_chk: assert property (@(posedge clk) disable iff (rst)
    byte_vld_o |-> (st != ST_HUNT));
  // R4
  start_has_byte_chk: assert property (@(posedge clk) disable iff (rst)
    cell_start_o |-> byte_vld_o);
endmodule

// File: tb/cell_delineator_tb.sv
`timescale 1ns/1ps
module cell_delineator_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bit_vld_i = 1'b0;
  logic       bit_i = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o, cell_start_o, locd_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  int out_idx = 0;
  int bit_cnt = 0;
  bit done = 1'b0;
  logic [7:0] exp_bytes [0:1199];

  // Per cell: {corrupt_hec, exp_locd, exp_state[1:0]} after its header.
  localparam logic [3:0] TBL [0:20] = '{
    4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h5, 4'h2,
    4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'h2,
    4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hA, 4'hC};

  cell_delineator u_dut (
    .clk(clk), .rst(rst), .bit_vld_i(bit_vld_i), .bit_i(bit_i),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o), .cell_start_o(cell_start_o),
    .state_o(state_o), .locd_o(locd_o));

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      logic f = c[7] ^ h[i];
      c = {c[6:0], 1'b0} ^ (f ? 8'h07 : 8'h00);
    end
    return c ^ 8'h55;
  endfunction

  task automatic build_cell(input int k, input bit bad, input int base);
    logic [31:0] h = {8'h0A, 8'(k * 3 + 1), 8'h3C, 8'hA0};
    logic [7:0]  e = ref_hec(h) ^ (bad ? 8'h01 : 8'h00);
    exp_bytes[base]   = h[31:24];
    exp_bytes[base+1] = h[23:16];
    exp_bytes[base+2] = h[15:8];
    exp_bytes[base+3] = h[7:0];
    exp_bytes[base+4] = e;
    for (int j = 5; j < 53; j++) exp_bytes[base+j] = 8'(k * 7 + j * 13);
  endtask

  task automatic monitor();
    if (byte_vld_o) begin
      chk(state_o != 2'd0, "R9 byte while hunting", state_o, 1);
      chk(byte_o == exp_bytes[out_idx], "R4 byte value", byte_o, exp_bytes[out_idx]);
      chk(cell_start_o == (out_idx % 53 == 0), "R4 cell start", cell_start_o, (out_idx % 53 == 0));
      out_idx++;
    end else begin
      chk(cell_start_o == 1'b0, "R4 start without byte", cell_start_o, 0);
    end
  endtask

  task automatic idle_cycle(input logic b);
    logic [1:0] ps = state_o;
    bit_vld_i = 1'b0;
    bit_i = ~b;
    @(posedge clk);
    @(negedge clk);
    chk(byte_vld_o == 1'b0, "R8 idle emits nothing", byte_vld_o, 0);
    chk(state_o == ps, "R8 idle keeps state", state_o, ps);
  endtask

  task automatic send_bit(input logic b);
    if (bit_cnt % 7 == 6) idle_cycle(b);
    bit_cnt++;
    bit_vld_i = 1'b1;
    bit_i = b;
    @(posedge clk);
    @(negedge clk);
    bit_vld_i = 1'b0;
    monitor();
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    bit_vld_i = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(state_o == 2'd0, "R1 reset state", state_o, 0);
    chk(locd_o == 1'b1, "R1 reset locd", locd_o, 1);
    chk(byte_vld_o == 1'b0 && cell_start_o == 1'b0, "R1 reset outputs", byte_vld_o, 0);
    rst = 1'b0;
    out_idx = 0;
  endtask

  initial begin
    @(negedge clk);
    // Table walk: acquisition, confirmation, tolerated errors, loss (R2 R5 R7).
    do_reset();
    for (int e = 0; e < 21; e++) begin
      build_cell(e, TBL[e][3], e * 53);
      for (int j = 0; j < 5; j++) send_byte(exp_bytes[e * 53 + j]);
      chk(state_o == TBL[e][1:0], "R5 R7 state after header", state_o, TBL[e][1:0]);
      chk(locd_o == TBL[e][2], "R5 R7 locd after header", locd_o, TBL[e][2]);
      if (e < 20) for (int j = 5; j < 53; j++) send_byte(exp_bytes[e * 53 + j]);
    end
    chk(out_idx == 1060, "R7 no byte on loss edge", out_idx, 1060);

    // R3 bit-exact acquisition timing after reset.
    do_reset();
    build_cell(30, 1'b0, 0);
    build_cell(31, 1'b1, 53);
    for (int i = 0; i < 40; i++) begin
      send_bit(exp_bytes[i / 8][7 - i % 8]);
      if (i < 39) chk(state_o == 2'd0, "R3 hunting before 40 bits", state_o, 0);
      else chk(state_o == 2'd1 && out_idx == 1, "R3 presync at header end", state_o, 1);
    end
    for (int j = 5; j < 53; j++) send_byte(exp_bytes[j]);
    // R6 one bad check in presync.
    for (int j = 53; j < 58; j++) send_byte(exp_bytes[j]);
    chk(state_o == 2'd0, "R6 back to hunt", state_o, 0);
    chk(locd_o == 1'b1, "R6 locd stays", locd_o, 1);
    chk(out_idx == 53, "R6 no byte on fail edge", out_idx, 53);

    // R3 header at an odd bit offset.
    do_reset();
    build_cell(40, 1'b0, 0);
    build_cell(41, 1'b0, 53);
    send_bit(1'b1);
    send_bit(1'b0);
    send_bit(1'b1);
    for (int j = 0; j < 5; j++) send_byte(exp_bytes[j]);
    chk(state_o == 2'd1, "R3 offset acquisition", state_o, 1);
    chk(out_idx == 1, "R3 offset first byte", out_idx, 1);
    for (int j = 5; j < 58; j++) send_byte(exp_bytes[j]);
    chk(state_o == 2'd1, "R5 second check keeps presync", state_o, 1);
    chk(out_idx == 54, "R4 byte count offset", out_idx, 54);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule